// File: doc/BRIEF.md
# Flash Programming Control Unit

This block sits between an 8-bit CPU bus and a small on-chip flash model. Software writes a control register to set three things: which flash space the code-read port sees, whether data-space writes land in a page-wide column-latch buffer, and a key nibble that guards the start of a program cycle. While the latch-select bit is set, data writes below 8000h do not reach normal memory. They fill the latch buffer byte by byte and record which page is the target.

A program cycle starts only after two control writes in a row: the first carries key 5h and the second carries key Ah. The target space is the mode written with the Ah key. For a fixed number of clock cycles the block reports busy. At the end it copies only the latch bytes written since the last launch into the target and clears the latch-valid flags. The flash model covers a parameterised number of user pages, one extra row and one security byte, and all of them reset to FFh.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset the control readback is 00h, busy is low and every code read returns FFh.
- R2: Control register layout: bits 7:4 are the key, bit 3 is busy (read-only), bit 2 is latch select and bits 1:0 are the mode. With latch select set, a data write to an address below 8000h raises neither memory strobe. Every other data write raises iram_we when xram_sel is low and xram_we when xram_sel is high.
- R3: Latch select overrides xram_sel for addresses below 8000h. Address bits 6:0 pick the latch byte and bits 14:7 pick the target page.
- R4: Code reads follow the mode. Mode 00 maps user bytes from 0000h. Mode 01 maps the extra row at FF80h–FFFFh. Mode 10 maps the security byte at 0000h only. Any address outside the mapped space reads FFh.
- R5: A control write with key 5h, followed directly by a control write with key Ah, launches programming. The low nibble of either write does not affect the key check.
- R6: Any control write with a key that breaks the 5h-then-Ah order returns the unlock logic to idle, so an Ah write alone launches nothing.
- R7: Busy rises on the clock edge that takes the Ah write and stays high for exactly PROG_LAT cycles. It is visible both on the busy port and in control bit 3.
- R8: While busy is high, code reads return FFh. Latch writes and launch attempts are ignored.
- R9: A program cycle writes only the latch bytes written since the previous launch. The other bytes of the target keep their contents, and no byte carries over to a later program cycle.
- R10: In mode 11, code reads return FFh, and a launch in mode 11 is rejected without raising busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register readback |
| xram_sel | input | 1 | External-RAM select from the auxiliary register |
| dw_we | input | 1 | Data-space write strobe |
| dw_addr | input | 16 | Data-space write address |
| dw_data | input | 8 | Data-space write data |
| iram_we | output | 1 | Write strobe to internal data memory |
| xram_we | output | 1 | Write strobe to external data memory |
| cr_addr | input | 16 | Code-space read address |
| cr_data | output | 8 | Code-space read data (combinational) |
| busy | output | 1 | Programming in progress |

## Verification
If the unlock state is wrong, busy rises or fails to rise on the edge right after the Ah write. That shows within one cycle on both the busy port and control bit 3. A wrong latch-valid mask or page register shows only after the program cycle ends: a byte that should still read FFh, or should keep an older value, reads differently. The bench therefore reads back neighbouring bytes and a second page after each program cycle. A wrong busy count shifts the falling edge, and the bench samples busy on the last high cycle and on the first low cycle.

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl #(
  parameter int PAGE_AW  = 7,
  parameter int UPAGE_AW = 3,
  parameter int PROG_LAT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        xram_sel,
  input  logic        dw_we,
  input  logic [15:0] dw_addr,
  input  logic [7:0]  dw_data,
  output logic        iram_we,
  output logic        xram_we,
  input  logic [15:0] cr_addr,
  output logic [7:0]  cr_data,
  output logic        busy
);
  localparam int PAGE_B  = 1 << PAGE_AW;
  localparam int USER_AW = PAGE_AW + UPAGE_AW;
  localparam int USER_B  = 1 << USER_AW;
  localparam int UPAGES  = 1 << UPAGE_AW;
  localparam int PG_W    = 15 - PAGE_AW;
  localparam int CNT_W   = $clog2(PROG_LAT + 1);

  logic [1:0]        mode_q, pmode_q;
  logic              lsel_q, armed_q, busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PG_W-1:0]   page_q;
  logic [7:0]        umem [USER_B];
  logic [7:0]        xrow [PAGE_B];
  logic [7:0]        lat  [PAGE_B];
  logic [PAGE_B-1:0] lvld;
  logic [7:0]        sec_q;

  wire [3:0] key     = cfg_wdata[7:4];
  wire       launch  = cfg_we && armed_q && key == 4'hA && !busy_q && cfg_wdata[1:0] != 2'b11;
  wire       lat_hit = dw_we && lsel_q && !dw_addr[15];
  wire       lat_we  = lat_hit && !busy_q;
  wire       page_ok = 32'(page_q) < UPAGES;

  assign iram_we   = dw_we && !lat_hit && !xram_sel;
  assign xram_we   = dw_we && !lat_hit && xram_sel;
  assign busy      = busy_q;
  assign cfg_rdata = {4'h0, busy_q, lsel_q, mode_q};

  always_comb begin
    cr_data = 8'hFF;
    if (!busy_q) begin
      case (mode_q)
        2'b00: if (cr_addr[15:USER_AW] == '0) cr_data = umem[cr_addr[USER_AW-1:0]];
        2'b01: if (&cr_addr[15:PAGE_AW]) cr_data = xrow[cr_addr[PAGE_AW-1:0]];
        2'b10: if (cr_addr == 16'h0000) cr_data = sec_q;
        default: cr_data = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      pmode_q <= '0;
      lsel_q  <= 1'b0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      page_q  <= '0;
      sec_q   <= 8'hFF;
      lvld    <= '0;
      for (int i = 0; i < USER_B; i++) umem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_B; i++) begin
        xrow[i] <= 8'hFF;
        lat[i]  <= 8'hFF;
      end
    end else begin
      if (cfg_we) begin
        mode_q  <= cfg_wdata[1:0];
        lsel_q  <= cfg_wdata[2];
        armed_q <= key == 4'h5;
      end
      if (launch) begin
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(PROG_LAT);
        pmode_q <= cfg_wdata[1:0];
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          lvld   <= '0;
          for (int i = 0; i < PAGE_B; i++) begin
            if (lvld[i]) begin
              case (pmode_q)
                2'b00: if (page_ok) umem[{page_q[UPAGE_AW-1:0], PAGE_AW'(i)}] <= lat[i];
                2'b01: xrow[i] <= lat[i];
                2'b10: if (i == 0) sec_q <= lat[i];
                default: ;
              endcase
            end
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (lat_we) begin
        lat[dw_addr[PAGE_AW-1:0]]  <= dw_data;
        lvld[dw_addr[PAGE_AW-1:0]] <= 1'b1;
        page_q <= dw_addr[14:PAGE_AW];
      end
    end
  end
endmodule

module flash_prog_ctl_chk #(
  parameter int PROG_LAT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        dw_we,
  input logic [15:0] dw_addr,
  input logic        iram_we,
  input logic        xram_we,
  input logic [7:0]  cr_data,
  input logic        busy
);
  int bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0;
    else        bcnt <= busy ? bcnt + 1 : 0;

  // R2
  latch_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_we && cfg_rdata[2] && !dw_addr[15]) |-> (!iram_we && !xram_we));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == PROG_LAT);
  // R7
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < PROG_LAT);
  // R5
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we && cfg_wdata[7:4] == 4'hA && cfg_wdata[1:0] != 2'b11));
  // R8
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cr_data == 8'hFF);
  // R10
  resv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[1:0] == 2'b11 |-> cr_data == 8'hFF);
endmodule

bind flash_prog_ctl flash_prog_ctl_chk #(.PROG_LAT(PROG_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .dw_we(dw_we), .dw_addr(dw_addr),
  .iram_we(iram_we), .xram_we(xram_we), .cr_data(cr_data), .busy(busy)
);

// File: tb/flash_prog_ctl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctl_tb;
  localparam int LAT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, xram_sel = 1'b0, dw_we = 1'b0;
  logic [7:0] cfg_wdata = '0, dw_data = '0;
  logic [15:0] dw_addr = '0, cr_addr = '0;
  logic [7:0] cfg_rdata, cr_data;
  logic iram_we, xram_we, busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_prog_ctl #(.PAGE_AW(7), .UPAGE_AW(3), .PROG_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .xram_sel(xram_sel), .dw_we(dw_we),
    .dw_addr(dw_addr), .dw_data(dw_data), .iram_we(iram_we),
    .xram_we(xram_we), .cr_addr(cr_addr), .cr_data(cr_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic lwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); dw_we = 1'b1; dw_addr = a; dw_data = d;
    @(negedge clk); dw_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
    cr_addr = a; #1;
    chk(req, {8'h00, cr_data}, {8'h00, exp});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cfg readback", {8'h00, cfg_rdata}, 16'h0000);
    chk("R1 busy", {15'h0, busy}, 16'h0000);
    rd("R1 user read", 16'h0000, 8'hFF);
  endtask

  task automatic t_route();
    @(negedge clk); dw_we = 1'b1; dw_addr = 16'h0100; xram_sel = 1'b0; #1;
    chk("R2 iram strobe", {14'h0, iram_we, xram_we}, 16'h0002);
    xram_sel = 1'b1; #1;
    chk("R2 xram strobe", {14'h0, iram_we, xram_we}, 16'h0001);
    @(negedge clk); dw_we = 1'b0;
    cfg(8'h04);
    @(negedge clk); dw_we = 1'b1; dw_addr = 16'h7F00; dw_data = 8'h00; #1;
    chk("R3 latch overrides xram", {14'h0, iram_we, xram_we}, 16'h0000);
    dw_addr = 16'h8000; #1;
    chk("R2 high addr passes", {14'h0, iram_we, xram_we}, 16'h0001);
    @(negedge clk); dw_we = 1'b0; xram_sel = 1'b0;
  endtask

  task automatic t_program();
    cfg(8'h04);
    lwrite(16'h0100, 8'h3C);
    lwrite(16'h0105, 8'h41);
    lwrite(16'h017F, 8'h9E);
    cfg(8'h54);
    chk("R7 no busy after 5h", {15'h0, busy}, 16'h0000);
    cfg(8'hA4);
    chk("R7 busy rises", {15'h0, busy}, 16'h0001);
    chk("R7 status bit", {8'h00, cfg_rdata}, 16'h000C);
    rd("R8 read during busy", 16'h0100, 8'hFF);
    lwrite(16'h010A, 8'h11);
    repeat (LAT - 3) @(negedge clk);
    chk("R7 busy last cycle", {15'h0, busy}, 16'h0001);
    @(negedge clk);
    chk("R7 busy falls", {15'h0, busy}, 16'h0000);
    rd("R9 byte 0", 16'h0100, 8'h3C);
    rd("R9 byte 5", 16'h0105, 8'h41);
    rd("R9 byte 127", 16'h017F, 8'h9E);
    rd("R8 busy latch write ignored", 16'h010A, 8'hFF);
    rd("R9 other page", 16'h0080, 8'hFF);
    lwrite(16'h0185, 8'h22);
    cfg(8'h54); cfg(8'hA4);
    wait_idle();
    rd("R9 new page byte 5", 16'h0185, 8'h22);
    rd("R9 no stale byte 0", 16'h0180, 8'hFF);
    rd("R9 older page kept", 16'h0105, 8'h41);
  endtask

  task automatic t_busy_launch();
    lwrite(16'h0200, 8'h66);
    cfg(8'h54); cfg(8'hA4);
    cfg(8'h54); cfg(8'hA4);
    wait_idle();
    @(negedge clk);
    chk("R8 launch during busy ignored", {15'h0, busy}, 16'h0000);
  endtask

  task automatic t_key();
    lwrite(16'h0300, 8'h77);
    cfg(8'h54); cfg(8'h04); cfg(8'hA4);
    chk("R6 broken order", {15'h0, busy}, 16'h0000);
    cfg(8'hA4);
    chk("R6 A alone", {15'h0, busy}, 16'h0000);
    cfg(8'h00);
    rd("R6 nothing programmed", 16'h0300, 8'hFF);
    cfg(8'h04);
    lwrite(16'h0003, 8'h5A);
    cfg(8'h5F); cfg(8'hA5);
    chk("R5 low nibble ignored", {15'h0, busy}, 16'h0001);
    wait_idle();
    rd("R4 extra row", 16'hFF83, 8'h5A);
    rd("R4 extra row unmapped", 16'h0003, 8'hFF);
    lwrite(16'h0000, 8'hC3);
    cfg(8'h56); cfg(8'hA6);
    wait_idle();
    rd("R4 security byte", 16'h0000, 8'hC3);
    rd("R4 security other addr", 16'h0001, 8'hFF);
    cfg(8'h04);
    rd("R4 user map", 16'h0105, 8'h41);
    rd("R4 user out of range", 16'h4000, 8'hFF);
  endtask

  task automatic t_reserved();
    cfg(8'h07);
    rd("R10 reserved read", 16'h0105, 8'hFF);
    cfg(8'h57); cfg(8'hA7);
    chk("R10 launch rejected", {15'h0, busy}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_program();
    t_busy_launch();
    t_key();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule